// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns up to six asynchronous interrupt pins into clean, per-pin interrupt requests for a downstream interrupt controller. Each pin is brought into the clock domain through a two-stage synchroniser. A small per-pin trigger stage then compares the synchronised level with its value one cycle earlier and decides, according to a programmable trigger code, whether the pin has an event this cycle.

Software sees four 32-bit registers on a simple write-enable / combinational-read port. The first holds one 4-bit field per pin with the trigger code. The second shows the synchronised pin levels. The third holds the pending bits, where a written 0 clears a bit. The fourth holds the enable bits. Each request output is the pin's pending bit gated by its enable bit. Edge codes latch the pending bit until software clears it. Level codes make the pending bit follow the active level. After reset every pin starts in low-level mode with requests disabled.

Top module: `extint_unit`

## Requirements
- R1: While and after reset, every 3-bit trigger code is 6 (low level), reading offset 0x0 gives 0x666666. The pending bits, the enable bits and every request output are 0.
- R2: Offset 0x4 returns in bit i the level of pin i, delayed by two clock edges through the synchroniser. Bits at and above NUM_PINS read 0, and writes to this offset have no effect.
- R3: Offset 0x0 holds pin i's code in bits [4i+2:4i], and these bits can be written and read back. Bit 4i+3 and all bits above the last field always read 0.
- R4: With code 1 (rising), a 0-to-1 pin change sets the pin's pending bit (offset 0x8, bit i) on the third clock edge after the change.
- R5: With code 2 (falling), a 1-to-0 pin change sets the pending bit with the same latency.
- R6: With code 3 (both), either change sets the pending bit with the same latency.
- R7: With code 5 (high level), the pending bit equals the synchronised level one edge later. A written 0 cannot keep it low while the level is high, and it returns to 0 when the level drops.
- R8: With code 6 (low level), the pending bit equals the inverted synchronised level one edge later.
- R9: Codes 0, 4 and 7 raise no pending bit. A pending bit set earlier keeps its value and can still be cleared.
- R10: Writing offset 0x8 clears, in edge and no-trigger modes, every pending bit whose data bit is 0 and leaves bits written 1 unchanged. An event in the same cycle wins over the clear.
- R11: Offset 0xC bits [NUM_PINS-1:0] are read/write enables, and irq_req_o[i] is high exactly when pending bit i and enable bit i are both 1.
- R12: Offsets other than 0x0, 0x4, 0x8 and 0xC read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wen | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_req_o | output | NUM_PINS | Per-pin request toward the interrupt controller |

## Verification
The bench builds the block with NUM_PINS at its maximum of six. This way every 4-bit field of the configuration register is live and the unused bits 31:24 can be checked for zero. It starts from the reset mode, where all pins are low-level triggered, and takes each trigger code through directed pin changes. A long random phase follows, mixing pin toggles with writes of arbitrary data to arbitrary offsets. That phase brings the reserved codes, clears that coincide with edges, and mode changes in the middle of an event within reach of a cycle-by-cycle model.

// File: rtl/extint_pkg.sv
package extint_pkg;

  localparam int MAX_PINS = 6;
  localparam int FIELD_W  = 4;
  localparam int CODE_W   = 3;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 4;

  localparam logic [ADDR_W-1:0] OFS_CFG = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CAP = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_PND = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_ENA = 4'hC;

  typedef enum logic [CODE_W-1:0] {
    TRG_OFF  = 3'd0,
    TRG_RISE = 3'd1,
    TRG_FALL = 3'd2,
    TRG_BOTH = 3'd3,
    TRG_RSV4 = 3'd4,
    TRG_HIGH = 3'd5,
    TRG_LOW  = 3'd6,
    TRG_RSV7 = 3'd7
  } trig_e;

  localparam logic [CODE_W-1:0] TRG_RESET = TRG_LOW;

  // level codes own the pending bit outright
  function automatic logic trig_is_level(trig_e t);
    return (t == TRG_HIGH) || (t == TRG_LOW);
  endfunction

  // edge qualification from current and previous synchronised level
  function automatic logic trig_edge_hit(trig_e t, logic cur, logic prv);
    logic hit;
    case (t)
      TRG_RISE: hit = cur & ~prv;
      TRG_FALL: hit = ~cur & prv;
      TRG_BOTH: hit = cur ^ prv;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

  // active level for the level codes
  function automatic logic trig_level_hit(trig_e t, logic cur);
    logic act;
    case (t)
      TRG_HIGH: act = cur;
      TRG_LOW:  act = ~cur;
      default:  act = 1'b0;
    endcase
    return act;
  endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/extint_detect.sv
module extint_detect
  import extint_pkg::*;
#(
  parameter int NUM_PINS = 6,
  localparam int CODES_W = NUM_PINS * CODE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] sync_lvl,
  input  logic [CODES_W-1:0]  cfg_codes,
  output logic [NUM_PINS-1:0] set_evt,
  output logic [NUM_PINS-1:0] lvl_mode,
  output logic [NUM_PINS-1:0] lvl_act
);

  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_lvl;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    trig_e code;
    assign code        = trig_e'(cfg_codes[CODE_W*i +: CODE_W]);
    assign set_evt[i]  = trig_edge_hit(code, sync_lvl[i], prev_q[i]);
    assign lvl_mode[i] = trig_is_level(code);
    assign lvl_act[i]  = trig_level_hit(code, sync_lvl[i]);
  end

endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int NUM_PINS = 6,
  localparam int CODES_W = NUM_PINS * CODE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wen,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] sync_lvl,
  input  logic [NUM_PINS-1:0] set_evt,
  input  logic [NUM_PINS-1:0] lvl_mode,
  input  logic [NUM_PINS-1:0] lvl_act,
  output logic [CODES_W-1:0]  cfg_codes,
  output logic [NUM_PINS-1:0] pend_q,
  output logic [NUM_PINS-1:0] en_q
);

  logic wr_cfg, wr_pnd, wr_ena;
  logic [CODE_W-1:0] cfg_q [NUM_PINS];

  assign wr_cfg = bus_wen && (bus_addr == OFS_CFG);
  assign wr_pnd = bus_wen && (bus_addr == OFS_PND);
  assign wr_ena = bus_wen && (bus_addr == OFS_ENA);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic clr_req;
    assign clr_req = wr_pnd && !bus_wdata[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q[i] <= TRG_RESET;
      else if (wr_cfg) cfg_q[i] <= bus_wdata[FIELD_W*i +: CODE_W];
    end

    // level mode tracks; otherwise set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pend_q[i] <= 1'b0;
      else if (lvl_mode[i]) pend_q[i] <= lvl_act[i];
      else if (set_evt[i])  pend_q[i] <= 1'b1;
      else if (clr_req)     pend_q[i] <= 1'b0;
    end

    assign cfg_codes[CODE_W*i +: CODE_W] = cfg_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_ena) en_q <= bus_wdata[NUM_PINS-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CFG: for (int i = 0; i < NUM_PINS; i++) bus_rdata[FIELD_W*i +: CODE_W] = cfg_q[i];
      OFS_CAP: bus_rdata[NUM_PINS-1:0] = sync_lvl;
      OFS_PND: bus_rdata[NUM_PINS-1:0] = pend_q;
      OFS_ENA: bus_rdata[NUM_PINS-1:0] = en_q;
      default: bus_rdata = '0;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^bus_wdata;

endmodule

// File: rtl/extint_unit.sv
module extint_unit
  import extint_pkg::*;
#(
  parameter int NUM_PINS    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [3:0]          bus_addr,
  input  logic                bus_wen,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NUM_PINS-1:0] irq_req_o
);

  localparam int CODES_W = NUM_PINS * CODE_W;

  logic [NUM_PINS-1:0] sync_lvl;
  logic [NUM_PINS-1:0] set_evt;
  logic [NUM_PINS-1:0] lvl_mode;
  logic [NUM_PINS-1:0] lvl_act;
  logic [NUM_PINS-1:0] pend_q;
  logic [NUM_PINS-1:0] en_q;
  logic [CODES_W-1:0]  cfg_codes;

  extint_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_i),
    .sync_o  (sync_lvl)
  );

  extint_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_lvl  (sync_lvl),
    .cfg_codes (cfg_codes),
    .set_evt   (set_evt),
    .lvl_mode  (lvl_mode),
    .lvl_act   (lvl_act)
  );

  extint_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sync_lvl  (sync_lvl),
    .set_evt   (set_evt),
    .lvl_mode  (lvl_mode),
    .lvl_act   (lvl_act),
    .cfg_codes (cfg_codes),
    .pend_q    (pend_q),
    .en_q      (en_q)
  );

  assign irq_req_o = pend_q & en_q;

endmodule

// File: rtl/extint_unit_chk.sv
module extint_unit_chk #(
  parameter int NUM_PINS = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pin_i,
  input logic [3:0]          bus_addr,
  input logic                bus_wen,
  input logic [31:0]         bus_wdata,
  input logic [NUM_PINS-1:0] irq_req_o,
  input logic [NUM_PINS-1:0] sync_lvl,
  input logic [NUM_PINS-1:0] set_evt,
  input logic [NUM_PINS-1:0] lvl_mode,
  input logic [NUM_PINS-1:0] lvl_act,
  input logic [NUM_PINS-1:0] pend_q,
  input logic [NUM_PINS-1:0] en_q
);

  logic [1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  logic pnd_wr;
  assign pnd_wr = bus_wen && (bus_addr == 4'h8);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> irq_req_o == '0);

  // R2
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd3) |-> sync_lvl == $past(pin_i, 2));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    // R4
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_evt[i] && !lvl_mode[i]) |=> pend_q[i]);

    // R7
    level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_mode[i] |=> pend_q[i] == $past(lvl_act[i]));

    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pnd_wr && !bus_wdata[i] && !set_evt[i] && !lvl_mode[i]) |=> !pend_q[i]);

    // R11
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req_o[i]) |-> (pend_q[i] && en_q[i]));
  end

  logic unused_wbits;
  assign unused_wbits = ^bus_wdata;

endmodule

bind extint_unit extint_unit_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin_i     (pin_i),
  .bus_addr  (bus_addr),
  .bus_wen   (bus_wen),
  .bus_wdata (bus_wdata),
  .irq_req_o (irq_req_o),
  .sync_lvl  (sync_lvl),
  .set_evt   (set_evt),
  .lvl_mode  (lvl_mode),
  .lvl_act   (lvl_act),
  .pend_q    (pend_q),
  .en_q      (en_q)
);

// File: tb/extint_unit_bench.sv
`timescale 1ns/1ps
module extint_unit_bench;

  localparam int N = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pins = '0;
  logic [3:0]    addr = '0;
  logic          wen = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  req;

  always #2.5 clk = ~clk;

  extint_unit #(.NUM_PINS(N)) u_extint_unit (
    .clk (clk), .rst_n (rst_n), .pin_i (pins),
    .bus_addr (addr), .bus_wen (wen), .bus_wdata (wdata),
    .bus_rdata (rdata), .irq_req_o (req)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural model: pin history queue, newest first
  int           m_code [N];
  bit [N-1:0]   m_pend, m_en;
  bit [N-1:0]   hist [$];

  function automatic bit [31:0] m_read(bit [3:0] a);
    bit [31:0] v = 0;
    case (a)
      4'h0: for (int i = 0; i < N; i++) v = v | (32'(m_code[i]) << (4 * i));
      4'h4: v = 32'(hist[1]);
      4'h8: v = 32'(m_pend);
      4'hC: v = 32'(m_en);
      default: v = 0;
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_code[i] = 6;
      m_pend = '0;
      m_en   = '0;
      hist   = '{'0, '0, '0};
    end else begin
      bit [N-1:0] now_s, old_s, np;
      now_s = hist[1];
      old_s = hist[2];
      for (int i = 0; i < N; i++) begin
        bit hit, clr;
        clr = wen && addr == 4'h8 && !wdata[i];
        hit = (m_code[i] == 1 && now_s[i] && !old_s[i]) ||
              (m_code[i] == 2 && !now_s[i] && old_s[i]) ||
              (m_code[i] == 3 && now_s[i] != old_s[i]);
        if (m_code[i] == 5)      np[i] = now_s[i];
        else if (m_code[i] == 6) np[i] = !now_s[i];
        else                     np[i] = hit || (m_pend[i] && !clr);
      end
      m_pend = np;
      if (wen && addr == 4'h0)
        for (int i = 0; i < N; i++) m_code[i] = int'((wdata >> (4 * i)) & 32'h7);
      if (wen && addr == 4'hC) m_en = wdata[N-1:0];
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  // per-cycle comparison, away from the clock edges
  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk({cur_req, " req"}, 32'(req), 32'(m_pend & m_en));
      chk({cur_req, " rdata"}, rdata, m_read(addr));
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wen = 1'b1;
    @(negedge clk); wen = 1'b0;
  endtask

  task automatic rd_chk(string rq, logic [3:0] a, logic [31:0] exp);
    @(negedge clk); addr = a; wen = 1'b0;
    #1.5;
    chk(rq, rdata, exp);
  endtask

  task automatic set_pins(logic [N-1:0] v);
    @(negedge clk); pins = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic report;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1 reset";
    rd_chk("R1 config after reset", 4'h0, 32'h0066_6666);
    chk("R1 req during reset", 32'(req), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R1 enable after reset", 4'hC, 32'h0);
    repeat (4) @(negedge clk);
    cur_req = "R8 low level";
    rd_chk("R8 idle low pins pend", 4'h8, 32'h3F);
    cur_req = "R11 enable";
    wr(4'hC, 32'h3F);
    rd_chk("R11 enable readback", 4'hC, 32'h3F);
    chk("R11 req all", 32'(req), 32'h3F);
    cur_req = "R2 capture";
    set_pins(6'h3F);
    rd_chk("R2 capture levels", 4'h4, 32'h3F);
    rd_chk("R8 high pins drop pend", 4'h8, 32'h0);
    wr(4'h4, 32'h0);
    rd_chk("R2 capture write ignored", 4'h4, 32'h3F);
    cur_req = "R3 config";
    wr(4'h0, 32'hFFFF_FFFF);
    rd_chk("R3 reserved bits read 0", 4'h0, 32'h0077_7777);
    wr(4'h0, 32'h0070_5321);
    rd_chk("R3 config readback", 4'h0, 32'h0070_5321);
    cur_req = "R7 high level";
    wr(4'h8, 32'h0);
    rd_chk("R7 clear cannot hold level", 4'h8, 32'h08);
    cur_req = "R5 falling";
    set_pins(6'h3C);
    rd_chk("R5 falling sets pin1", 4'h8, 32'h0A);
    cur_req = "R4 rising";
    set_pins(6'h3F);
    rd_chk("R4 rising sets pin0", 4'h8, 32'h0B);
    cur_req = "R6 both R9 none";
    set_pins(6'h03);
    rd_chk("R6 R9 both and reserved", 4'h8, 32'h07);
    cur_req = "R10 clear";
    wr(4'h8, 32'hFFFF_FFFE);
    rd_chk("R10 clear one bit", 4'h8, 32'h06);
    wr(4'h8, 32'hFFFF_FFFF);
    rd_chk("R10 ones leave bits", 4'h8, 32'h06);
    cur_req = "R12 unmapped";
    wr(4'h2, 32'hFFFF_FFFF);
    rd_chk("R12 unmapped reads 0", 4'h2, 32'h0);
    rd_chk("R12 config untouched", 4'h0, 32'h0070_5321);
    cur_req = "R11 gating";
    wr(4'hC, 32'h02);
    chk("R11 req gated", 32'(req), 32'h02);
    cur_req = "R4/R5/R6/R7/R8/R9/R10/R12 random";
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      wen = 1'b0;
      if ($urandom % 3 == 0) pins = pins ^ N'(1 << ($urandom % N));
      addr = 4'($urandom);
      if ($urandom % 6 == 0) begin
        wdata = $urandom;
        wen = 1'b1;
      end
    end
    @(negedge clk); wen = 1'b0;
    repeat (2) @(negedge clk);
    report();
  end

endmodule